// File: doc/BRIEF.md
# YUV to RGB Pixel Converter

This block turns a stream of 8-bit luma and chroma samples into 8-bit red, green and blue codes for three downstream DAC channels, one pixel per clock. Luma arrives on one byte lane and chroma on a second. In the 4:2:2 formats the chroma lane alternates Cb and Cr. Each pixel is converted with the most recent Cb and Cr of the current line, using the standard-definition studio-range YCbCr equations in fixed point. Each result is clamped to the code range.

Two configuration inputs steer the datapath. One picks how chroma bytes are encoded: signed two's complement, or offset binary centred on 128. The other is a 2-bit format code. It selects 4:2:2 colour, luma-only grey, or a 16-bit 5:6:5 RGB mode that skips the matrix and widens each field to 8 bits.

A line-reference input marks active video. Its rising edge starts a line, and pixels sampled while it is low leave the block as code 0 on all channels. The path is three registers deep. The line-reference travels with the data, so blanking and pixels stay aligned.

Top module: `yuvrgb_pixel_conv`

## Requirements
- R1: With `chroma_offset_bin` = 0 a chroma byte is a signed two's-complement value. With it at 1 the byte is offset binary, and the signed value is the byte minus 128.
- R2: `pix_fmt` codes: 2'b00 = YCbCr 4:2:2, 2'b01 = RGB 5:6:5 bypass, 2'b10 = luma only, 2'b11 = YCbCr 4:2:2 (same behaviour as 2'b00).
- R3: In the 4:2:2 formats the first active pixel after a rising edge of `line_ref` carries Cb, and the next carries Cr, alternating from there. Each pixel uses the latest Cb and Cr of the line. Cr counts as 0 until the first Cr of the line arrives.
- R4: Outputs follow R = 1.164(Y-16)+1.596Cr, G = 1.164(Y-16)-0.813Cr-0.391Cb, B = 1.164(Y-16)+2.018Cb, each within 1.5 LSB of the exact clamped value.
- R5: In 5:6:5 mode `c_in[7:3]` is red, `{c_in[2:0], y_in[7:5]}` is green and `y_in[4:0]` is blue. Each field widens to 8 bits by copying its top bits below its LSB, for example R = {r5, r5[4:2]}.
- R6: Inputs sampled at a rising clock edge show on the outputs after the second edge that follows it, which is three register stages.
- R7: A pixel sampled while `line_ref` is low leaves as code 0 on all three outputs.
- R8: While `rst_n` is low the outputs are 0 at once. They stay 0 until the first pixel sampled after release reaches the outputs.
- R9: In luma-only mode chroma is treated as zero, so R, G and B are equal.
- R10: Results above 255 saturate to 255, and results below 0 saturate to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chroma_offset_bin | input | 1 | Chroma encoding: 0 two's complement, 1 offset binary |
| pix_fmt | input | 2 | Input format code |
| line_ref | input | 1 | High during active video |
| y_in | input | 8 | Luma lane (low byte in 5:6:5 mode) |
| c_in | input | 8 | Chroma lane (high byte in 5:6:5 mode) |
| r_out | output | 8 | Red code |
| g_out | output | 8 | Green code |
| b_out | output | 8 | Blue code |

## Verification
The bench targets the first pixels of each line. A design that does not clear its held Cr at the rising edge of `line_ref` carries a colour cast in from the previous line. A design that starts the Cb/Cr alternation on the wrong phase swaps the chroma components. Vectors with full-scale Cr and Cb push the matrix past both ends of the code range, where a missing or wrapped clamp gives codes far off the expected value. A single-pixel pulse and a mid-stream reset pin down the three-clock alignment of data and blanking, and the 5:6:5 vectors expose a field taken from the wrong bits.

// File: rtl/yuvrgb_pkg.sv
package yuvrgb_pkg;

   typedef enum logic [1:0] {
      FMT_YUV422     = 2'b00,
      FMT_RGB565     = 2'b01,
      FMT_LUMA       = 2'b10,
      FMT_YUV422_ALT = 2'b11
   } pix_fmt_e;

   // Fixed-point coefficient from a value in thousandths, rounded to nearest
   function automatic int fix_coef(input int milli, input int frac_w);
      int mag;
      mag = milli < 0 ? -milli : milli;
      mag = (mag * (1 << frac_w) + 500) / 1000;
      return milli < 0 ? -mag : mag;
   endfunction

   // Per-channel matrix terms in thousandths: channel 0 red, 1 green, 2 blue
   function automatic int luma_milli(input int ch);
      return ch >= 0 ? 1164 : 0;
   endfunction

   function automatic int cb_milli(input int ch);
      case (ch)
         1:       return -391;
         2:       return 2018;
         default: return 0;
      endcase
   endfunction

   function automatic int cr_milli(input int ch);
      case (ch)
         0:       return 1596;
         1:       return -813;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/yuvrgb_front.sv
module yuvrgb_front
   import yuvrgb_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     offset_bin,
   input  logic [1:0]               fmt,
   input  logic                     line_ref,
   input  logic [DATA_W-1:0]        y_in,
   input  logic [DATA_W-1:0]        c_in,
   output logic                     s1_active,
   output logic                     s1_bypass,
   output logic signed [DATA_W:0]   s1_yd,
   output logic signed [DATA_W-1:0] s1_cb,
   output logic signed [DATA_W-1:0] s1_cr,
   output logic [DATA_W-1:0]        s1_r,
   output logic [DATA_W-1:0]        s1_g,
   output logic [DATA_W-1:0]        s1_b
);

   localparam int YOFS = 16 << (DATA_W - 8);

   logic                     lr_q;
   logic                     phase_q;   // 1: next pixel carries Cr
   logic signed [DATA_W-1:0] cb_hold;
   logic signed [DATA_W-1:0] cr_hold;
   logic                     rise;
   logic                     cur_cr;
   logic signed [DATA_W-1:0] c_signed;
   logic signed [DATA_W-1:0] cb_use;
   logic signed [DATA_W-1:0] cr_use;
   logic signed [DATA_W:0]   yd_d;
   logic                     luma_only;
   logic                     byp_d;
   logic [DATA_W-1:0]        r_x, g_x, b_x;

   assign rise      = line_ref & ~lr_q;
   assign cur_cr    = rise ? 1'b0 : phase_q;
   // offset binary: flipping the sign bit subtracts the mid code
   assign c_signed  = {c_in[DATA_W-1] ^ offset_bin, c_in[DATA_W-2:0]};
   assign yd_d      = $signed({1'b0, y_in}) - (DATA_W+1)'(YOFS);
   assign luma_only = (fmt == FMT_LUMA);

   always_comb begin
      if (luma_only) begin
         cb_use = '0;
         cr_use = '0;
      end else if (cur_cr) begin
         cb_use = cb_hold;
         cr_use = c_signed;
      end else begin
         cb_use = c_signed;
         cr_use = rise ? '0 : cr_hold;
      end
   end

   generate
      if (BYPASS_EN) begin : g_bypass
         logic [4:0] r5, b5;
         logic [5:0] g6;
         assign r5    = c_in[7:3];
         assign g6    = {c_in[2:0], y_in[7:5]};
         assign b5    = y_in[4:0];
         assign r_x   = {r5, r5[4:2]};
         assign g_x   = {g6, g6[5:4]};
         assign b_x   = {b5, b5[4:2]};
         assign byp_d = (fmt == FMT_RGB565);
      end else begin : g_no_bypass
         assign r_x   = '0;
         assign g_x   = '0;
         assign b_x   = '0;
         assign byp_d = 1'b0;
      end
   endgenerate

   // chroma phase and held samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_q    <= 1'b0;
         phase_q <= 1'b0;
         cb_hold <= '0;
         cr_hold <= '0;
      end else begin
         lr_q <= line_ref;
         if (line_ref) begin
            phase_q <= ~cur_cr;
            if (cur_cr) cr_hold <= c_signed;
            else        cb_hold <= c_signed;
            if (rise)   cr_hold <= '0;
         end
      end
   end

   // stage 1 register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_active <= 1'b0;
         s1_bypass <= 1'b0;
         s1_yd     <= '0;
         s1_cb     <= '0;
         s1_cr     <= '0;
         s1_r      <= '0;
         s1_g      <= '0;
         s1_b      <= '0;
      end else begin
         s1_active <= line_ref;
         s1_bypass <= byp_d;
         s1_yd     <= yd_d;
         s1_cb     <= cb_use;
         s1_cr     <= cr_use;
         s1_r      <= r_x;
         s1_g      <= g_x;
         s1_b      <= b_x;
      end
   end

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(line_ref) && $past(lr_q)) |-> (phase_q != $past(phase_q))) else $error("phase did not alternate"); // R3

   AST_CR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(line_ref) && !$past(lr_q)) |-> (cr_hold == '0)) else $error("Cr not cleared at line start"); // R3

endmodule

// File: rtl/yuvrgb_chan.sv
module yuvrgb_chan #(
   parameter int DATA_W = 8,
   parameter int FRAC_W = 10,
   parameter int KY     = 1192,
   parameter int KCB    = 0,
   parameter int KCR    = 1634
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     active_i,
   input  logic                     bypass_i,
   input  logic [DATA_W-1:0]        byp_i,
   input  logic signed [DATA_W:0]   yd_i,
   input  logic signed [DATA_W-1:0] cb_i,
   input  logic signed [DATA_W-1:0] cr_i,
   output logic [DATA_W-1:0]        code_o
);

   localparam int ACC_W = DATA_W + FRAC_W + 6;
   localparam logic signed [ACC_W-1:0] KY_S     = ACC_W'(KY);
   localparam logic signed [ACC_W-1:0] KCB_S    = ACC_W'(KCB);
   localparam logic signed [ACC_W-1:0] KCR_S    = ACC_W'(KCR);
   localparam logic signed [ACC_W-1:0] RND      = ACC_W'(1 << (FRAC_W - 1));
   localparam logic signed [ACC_W-1:0] CODE_MAX = ACC_W'((1 << DATA_W) - 1);

   logic signed [ACC_W-1:0] yd_x, cb_x, cr_x;
   logic signed [ACC_W-1:0] sum_d;
   logic signed [ACC_W-1:0] acc_q;
   logic                    act_q, byp_q;
   logic [DATA_W-1:0]       bval_q;
   logic signed [ACC_W-1:0] scaled;
   logic [DATA_W-1:0]       sat;

   assign yd_x  = {{(ACC_W-DATA_W-1){yd_i[DATA_W]}}, yd_i};
   assign cb_x  = {{(ACC_W-DATA_W){cb_i[DATA_W-1]}}, cb_i};
   assign cr_x  = {{(ACC_W-DATA_W){cr_i[DATA_W-1]}}, cr_i};
   assign sum_d = yd_x * KY_S + cb_x * KCB_S + cr_x * KCR_S + RND;

   // stage 2: products summed with rounding offset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         act_q  <= 1'b0;
         byp_q  <= 1'b0;
         bval_q <= '0;
      end else begin
         acc_q  <= sum_d;
         act_q  <= active_i;
         byp_q  <= bypass_i;
         bval_q <= byp_i;
      end
   end

   assign scaled = acc_q >>> FRAC_W;

   always_comb begin
      if (scaled < 0)             sat = '0;
      else if (scaled > CODE_MAX) sat = '1;
      else                        sat = scaled[DATA_W-1:0];
   end

   // stage 3: clamp, path select, blanking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code_o <= '0;
      else if (!act_q) code_o <= '0;
      else if (byp_q)  code_o <= bval_q;
      else             code_o <= sat;
   end

   AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !byp_q && (scaled > CODE_MAX)) |=> (code_o == '1)) else $error("no high saturation"); // R10

   AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !byp_q && (scaled < 0)) |=> (code_o == '0)) else $error("no low saturation"); // R10

endmodule

// File: rtl/yuvrgb_pixel_conv.sv
module yuvrgb_pixel_conv
   import yuvrgb_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int FRAC_W    = 10,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chroma_offset_bin,
   input  logic [1:0]        pix_fmt,
   input  logic              line_ref,
   input  logic [DATA_W-1:0] y_in,
   input  logic [DATA_W-1:0] c_in,
   output logic [DATA_W-1:0] r_out,
   output logic [DATA_W-1:0] g_out,
   output logic [DATA_W-1:0] b_out
);

   localparam int NCH = 3;

   generate
      if (DATA_W < 8 || DATA_W > 12) begin : g_bad_dw
         $error("DATA_W must lie in 8..12");
      end
      if (FRAC_W < 6 || FRAC_W > 14) begin : g_bad_fw
         $error("FRAC_W must lie in 6..14");
      end
      if (BYPASS_EN && DATA_W != 8) begin : g_bad_byp
         $error("5:6:5 bypass needs DATA_W of 8");
      end
   endgenerate

   logic                     s1_active, s1_bypass;
   logic signed [DATA_W:0]   s1_yd;
   logic signed [DATA_W-1:0] s1_cb, s1_cr;
   logic [DATA_W-1:0]        s1_r, s1_g, s1_b;
   logic [DATA_W-1:0]        byp_ch [NCH];
   logic [DATA_W-1:0]        code_ch [NCH];

   yuvrgb_front #(
      .DATA_W    (DATA_W),
      .BYPASS_EN (BYPASS_EN)
   ) u_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .offset_bin (chroma_offset_bin),
      .fmt        (pix_fmt),
      .line_ref   (line_ref),
      .y_in       (y_in),
      .c_in       (c_in),
      .s1_active  (s1_active),
      .s1_bypass  (s1_bypass),
      .s1_yd      (s1_yd),
      .s1_cb      (s1_cb),
      .s1_cr      (s1_cr),
      .s1_r       (s1_r),
      .s1_g       (s1_g),
      .s1_b       (s1_b)
   );

   assign byp_ch[0] = s1_r;
   assign byp_ch[1] = s1_g;
   assign byp_ch[2] = s1_b;

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         yuvrgb_chan #(
            .DATA_W (DATA_W),
            .FRAC_W (FRAC_W),
            .KY     (fix_coef(luma_milli(ch), FRAC_W)),
            .KCB    (fix_coef(cb_milli(ch), FRAC_W)),
            .KCR    (fix_coef(cr_milli(ch), FRAC_W))
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (s1_active),
            .bypass_i (s1_bypass),
            .byp_i    (byp_ch[ch]),
            .yd_i     (s1_yd),
            .cb_i     (s1_cb),
            .cr_i     (s1_cr),
            .code_o   (code_ch[ch])
         );
      end
   endgenerate

   assign r_out = code_ch[0];
   assign g_out = code_ch[1];
   assign b_out = code_ch[2];

   // clocks since reset, saturating, so $past depth 3 stays inside that window
   logic [1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end

   AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd3 && !$past(line_ref, 3)) |-> (r_out == '0 && g_out == '0 && b_out == '0)) else $error("active output while blanked"); // R7

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q != 2'd3) |-> (r_out == '0 && g_out == '0 && b_out == '0)) else $error("output before first pixel"); // R8

   AST_GRAY_LUMA: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd3 && $past(line_ref, 3) && $past(pix_fmt, 3) == FMT_LUMA) |-> (r_out == g_out && g_out == b_out)) else $error("luma-only pixel not grey"); // R9

   generate
      if (BYPASS_EN) begin : g_byp_chk
         AST_BYPASS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd3 && $past(line_ref, 3) && $past(pix_fmt, 3) == FMT_RGB565)
            |-> (r_out[DATA_W-1:DATA_W-5] == $past(c_in[7:3], 3) && b_out[DATA_W-1:DATA_W-5] == $past(y_in[4:0], 3))) else $error("bypass fields misplaced"); // R5
      end
   endgenerate

endmodule

// File: tb/tb_yuvrgb_pixel_conv.sv
module tb_yuvrgb_pixel_conv;

   localparam int N = 28;
   // {line_ref, pix_fmt[1:0], offset_bin, y[7:0], c[7:0]}
   localparam logic [19:0] VEC [N] = '{
      {1'b0, 2'b00, 1'b0, 8'd80,  8'h00},
      {1'b0, 2'b00, 1'b0, 8'd80,  8'h00},
      {1'b1, 2'b00, 1'b1, 8'd128, 8'hA0},
      {1'b1, 2'b00, 1'b1, 8'd128, 8'h60},
      {1'b1, 2'b00, 1'b1, 8'd200, 8'h90},
      {1'b1, 2'b00, 1'b1, 8'd60,  8'h70},
      {1'b1, 2'b00, 1'b0, 8'd100, 8'h20},
      {1'b1, 2'b00, 1'b0, 8'd100, 8'hE0},
      {1'b1, 2'b00, 1'b0, 8'd235, 8'h00},
      {1'b1, 2'b00, 1'b0, 8'd235, 8'h7F},
      {1'b1, 2'b00, 1'b0, 8'd16,  8'h80},
      {1'b1, 2'b00, 1'b0, 8'd16,  8'h80},
      {1'b0, 2'b00, 1'b0, 8'd200, 8'h40},
      {1'b1, 2'b01, 1'b0, 8'hA5,  8'h5C},
      {1'b1, 2'b01, 1'b0, 8'hFF,  8'hFF},
      {1'b1, 2'b01, 1'b0, 8'h00,  8'h00},
      {1'b1, 2'b01, 1'b0, 8'h1F,  8'hE0},
      {1'b0, 2'b01, 1'b0, 8'hFF,  8'hFF},
      {1'b1, 2'b10, 1'b0, 8'd50,  8'h55},
      {1'b1, 2'b10, 1'b1, 8'd255, 8'h00},
      {1'b1, 2'b10, 1'b0, 8'd16,  8'h7F},
      {1'b0, 2'b10, 1'b0, 8'd90,  8'h10},
      {1'b1, 2'b11, 1'b1, 8'd90,  8'h10},
      {1'b1, 2'b11, 1'b1, 8'd150, 8'hF0},
      {1'b1, 2'b11, 1'b1, 8'd180, 8'h80},
      {1'b0, 2'b00, 1'b0, 8'd0,   8'h00},
      {1'b0, 2'b00, 1'b0, 8'd0,   8'h00},
      {1'b0, 2'b00, 1'b0, 8'd0,   8'h00}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chroma_offset_bin = 1'b0;
   logic [1:0] pix_fmt = 2'b00;
   logic       line_ref = 1'b0;
   logic [7:0] y_in = '0;
   logic [7:0] c_in = '0;
   logic [7:0] r_out, g_out, b_out;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   yuvrgb_pixel_conv dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .chroma_offset_bin (chroma_offset_bin),
      .pix_fmt           (pix_fmt),
      .line_ref          (line_ref),
      .y_in              (y_in),
      .c_in              (c_in),
      .r_out             (r_out),
      .g_out             (g_out),
      .b_out             (b_out)
   );

   // expected values per vector
   real   e_r [N];
   real   e_g [N];
   real   e_b [N];
   bit    e_exact [N];
   string e_tag [N];

   // reference model state
   bit m_lr_prev = 1'b0;
   bit m_phase = 1'b0;
   int m_cb = 0;
   int m_cr = 0;

   task automatic chk_eq(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic chk_near(input string tag, input string what, input int act, input real exp);
      real d;
      n_chk++;
      d = real'(act) - exp;
      if (d < 0.0) d = -d;
      if (d > 1.5) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %f", tag, what, act, exp);
      end
   endtask

   function automatic real clamp8(input real v);
      if (v < 0.0) return 0.0;
      if (v > 255.0) return 255.0;
      return v;
   endfunction

   function automatic int widen(input int v, input int w);
      return (v << (8 - w)) | (v >> (2 * w - 8));
   endfunction

   task automatic model(input int i);
      logic [19:0] v;
      bit lr, ob, rise, is_cr;
      logic [1:0] f;
      int y, c, cs, cb, cr;
      real yy, rr, gg, bb;
      v  = VEC[i];
      lr = v[19]; f = v[18:17]; ob = v[16];
      y  = int'(v[15:8]); c = int'(v[7:0]);
      cs = ob ? c - 128 : (c >= 128 ? c - 256 : c);
      rise = lr && !m_lr_prev;
      m_lr_prev = lr;
      e_exact[i] = 1'b1;
      if (!lr) begin
         e_r[i] = 0.0; e_g[i] = 0.0; e_b[i] = 0.0;
         e_tag[i] = "R7";
         return;
      end
      is_cr = rise ? 1'b0 : m_phase;
      cb = is_cr ? m_cb : cs;
      cr = is_cr ? cs : (rise ? 0 : m_cr);
      m_phase = !is_cr;
      if (is_cr) m_cr = cs; else m_cb = cs;
      if (rise) m_cr = 0;
      if (f == 2'b01) begin
         // R5: red c[7:3], green {c[2:0],y[7:5]}, blue y[4:0]
         e_r[i] = real'(widen(c >> 3, 5));
         e_g[i] = real'(widen(((c & 7) << 3) | (y >> 5), 6));
         e_b[i] = real'(widen(y & 31, 5));
         e_tag[i] = "R5";
         return;
      end
      if (f == 2'b10) begin cb = 0; cr = 0; end
      yy = 1.164 * real'(y - 16);
      rr = yy + 1.596 * real'(cr);
      gg = yy - 0.813 * real'(cr) - 0.391 * real'(cb);
      bb = yy + 2.018 * real'(cb);
      e_r[i] = clamp8(rr); e_g[i] = clamp8(gg); e_b[i] = clamp8(bb);
      e_exact[i] = 1'b0;
      if (rr < 0.0 || rr > 255.0 || gg < 0.0 || gg > 255.0 || bb < 0.0 || bb > 255.0)
         e_tag[i] = "R10";
      else if (f == 2'b11) e_tag[i] = "R2";
      else if (f == 2'b10) e_tag[i] = "R9";
      else if (ob)         e_tag[i] = "R1";
      else if (is_cr)      e_tag[i] = "R3";
      else                 e_tag[i] = "R4";
   endtask

   task automatic check_vec(input int i);
      string w;
      w = $sformatf("vec%0d", i);
      if (e_exact[i]) begin
         chk_eq(e_tag[i], {w, " red"},   int'(r_out), int'(e_r[i]));
         chk_eq(e_tag[i], {w, " green"}, int'(g_out), int'(e_g[i]));
         chk_eq(e_tag[i], {w, " blue"},  int'(b_out), int'(e_b[i]));
      end else begin
         chk_near(e_tag[i], {w, " red"},   int'(r_out), e_r[i]);
         chk_near(e_tag[i], {w, " green"}, int'(g_out), e_g[i]);
         chk_near(e_tag[i], {w, " blue"},  int'(b_out), e_b[i]);
         if (e_tag[i] == "R9") begin
            chk_eq("R9", {w, " grey r=g"}, int'(r_out), int'(g_out));
            chk_eq("R9", {w, " grey g=b"}, int'(g_out), int'(b_out));
         end
      end
   endtask

   task automatic drive(input bit lr, input logic [1:0] f, input bit ob, input logic [7:0] y, input logic [7:0] c);
      line_ref = lr; pix_fmt = f; chroma_offset_bin = ob; y_in = y; c_in = c;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_eq("R8", "red in reset",   int'(r_out), 0);
      chk_eq("R8", "green in reset", int'(g_out), 0);
      chk_eq("R8", "blue in reset",  int'(b_out), 0);
      rst_n = 1'b1;

      // vector table walk: vector i is checked three clocks after it is driven (R6)
      for (int i = 0; i < N + 3; i++) begin
         @(negedge clk);
         if (i >= 3) check_vec(i - 3);
         if (i < N) begin
            drive(VEC[i][19], VEC[i][18:17], VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
            model(i);
         end else begin
            drive(1'b0, 2'b00, 1'b0, 8'h00, 8'h00);
         end
      end

      // R6: single white pixel in bypass mode appears exactly three clocks later
      @(negedge clk);
      drive(1'b1, 2'b01, 1'b0, 8'hFF, 8'hFF);
      @(negedge clk);
      drive(1'b0, 2'b00, 1'b0, 8'h00, 8'h00);
      chk_eq("R6", "pulse after 1 clock", int'(r_out), 0);
      @(negedge clk);
      chk_eq("R6", "pulse after 2 clocks", int'(r_out), 0);
      @(negedge clk);
      chk_eq("R6", "pulse red after 3 clocks", int'(r_out), 255);
      chk_eq("R6", "pulse blue after 3 clocks", int'(b_out), 255);
      @(negedge clk);
      chk_eq("R7", "blank after pulse", int'(g_out), 0);

      // R8: reset while active video is flowing
      drive(1'b1, 2'b01, 1'b0, 8'hFF, 8'hFF);
      repeat (4) @(negedge clk);
      chk_eq("R5", "steady white", int'(g_out), 255);
      rst_n = 1'b0;
      #1;
      chk_eq("R8", "red cleared by reset", int'(r_out), 0);
      chk_eq("R8", "blue cleared by reset", int'(b_out), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R8", "quiet 1 clock after release", int'(r_out), 0);
      repeat (2) @(negedge clk);
      chk_eq("R8", "first pixel after release", int'(r_out), 255);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule